// File: doc/BRIEF.md
# Microwire-style serial EEPROM command front end

This block is the slave side of a three-wire serial memory interface. It oversamples chip select, serial clock and serial data in the system clock domain. It waits for a start bit, shifts in a two-bit opcode, an address and, for the data-carrying commands, a data word. It then decodes one of seven commands. Reads are served from a small word array held inside the block. A read sends a leading zero bit and then the word, and it keeps streaming words from consecutive addresses for as long as select stays high.

The programming commands are write one location, erase one location, erase everything and write everything. Each one is handed to an external programming sequencer as a single-cycle request, issued when select falls after a complete frame. The same request also commits the change to the local array, so later reads return it. An organisation strap chooses between 16-bit words and 8-bit bytes. In byte mode the address is one bit longer. Programming is locked after reset and is unlocked and relocked by two of the extended commands.

Top module: `mw_serial_eeprom`

## Requirements
- R1: A frame starts only on the first rising serial-clock edge that sees `cs` and `di` both high. Rising edges with `di` low before that have no effect, and DO stays released.
- R2: Every serial input bit is sampled on a rising serial-clock edge. The DO bit changes only in the system cycle that follows a rising serial-clock edge, and it holds between edges.
- R3: After the start bit, the next two bits are the opcode, first bit most significant: 2'b10 reads, 2'b01 writes one location (the address is followed by a data word) and 2'b11 erases one location to all ones.
- R4: Opcode 2'b00 takes its sub-command from the two most significant address bits: 2'b11 unlocks programming, 2'b00 locks it, 2'b10 erases all, and 2'b01 writes all (followed by a data word). The remaining address bits are ignored.
- R5: `org` is captured at the start bit. With `org`=1 a location is a 16-bit word with ADDR_W address bits. With `org`=0 a location is a byte with ADDR_W+1 address bits, and byte address bit 0 selects the low (0) or high (1) half of a word. Address and data are sent most significant bit first.
- R6: On the rising edge that carries the last address bit of a read, DO is enabled and driven 0. Each following rising edge presents the next data bit, most significant first.
- R7: While `cs` stays high, a read continues with the next location and no gap. The address wraps from the last location to 0.
- R8: A frame is complete after 3+ADDR_W clocks, plus one more address bit in byte mode and plus one word for write and write-all. For the defaults, write in word mode takes 25 clocks and erase takes 9. After a frame completes, further clocks and data are ignored until `cs` goes low.
- R9: When `cs` is low, the frame logic returns to waiting for a start bit. `do_oe` is low in every cycle in which `cs` is low, so a read is cut off at once.
- R10: `prog_req` pulses for exactly one cycle, in the first cycle `cs` is seen low, and only if a complete programming frame was received while programming was unlocked. Programming is locked after reset. A frame cut short, or one sent while locked, produces no pulse.
- R11: After reset every location reads all ones. A write stores the data, an erase sets one location to all ones, erase-all sets the whole array to ones, and write-all fills every location (every byte in byte mode) with the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, high selects the block |
| sclk | input | 1 | Serial clock from the bus master |
| di | input | 1 | Serial data into the block |
| org | input | 1 | Organisation strap: 1 word mode, 0 byte mode |
| do_o | output | 1 | Serial data out, 0 when not enabled |
| do_oe | output | 1 | Output enable for the DO pad driver |
| prog_req | output | 1 | One-cycle programming request |
| prog_op | output | 2 | Request kind: 0 write, 1 erase, 2 erase all, 3 write all |
| prog_addr | output | ADDR_W+1 | Location address of the request |
| prog_data | output | DATA_W | Data of the request (byte in low bits in byte mode) |
| prog_x8 | output | 1 | Request was made in byte mode |

## Verification
The hardest states to reach from the ports are where frame control meets storage. One is a read that streams across the top address and back to zero. It is reached by writing the last and first locations, then holding select high for three words' worth of clocks. The other is a write frame that is almost complete when select drops. The bench sends the first 20 of 25 bits, releases select, and reads the location back to prove nothing was committed. A behavioural reference model runs alongside and predicts DO, its enable and every request on each clock. It also tracks the lock state across both organisations, so locked writes, trailing clocks after a complete erase, and byte/word aliasing are all checked against the same prediction.

// File: rtl/mw_pkg.sv
// Shared encodings for the serial EEPROM front end.
// Assumes: opcode and sub-command values match the bus protocol bit order.
package mw_pkg;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_CLEAR  = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

    typedef enum logic [1:0] {
        PRG_WRITE = 2'd0,
        PRG_ERASE = 2'd1,
        PRG_ERAL  = 2'd2,
        PRG_WRAL  = 2'd3
    } prg_op_t;

    typedef enum logic [1:0] {
        FR_WAIT  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_READ  = 2'd2,
        FR_DONE  = 2'd3
    } fr_state_t;

endpackage

// File: rtl/mw_frame_rx.sv
// Frame receiver: finds the start bit, shifts opcode/address/data, decodes
// commands, holds the programming lock and raises the programming request.
// Assumes: cs_fall and sclk_rise are single-cycle strobes from the top level,
// and org is stable while a frame is being received.
module mw_frame_rx
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              cs_fall,
    input  logic              sclk_rise,
    input  logic              di,
    input  logic              org,
    output logic              rd_start,
    output logic [ADDR_W:0]   rd_addr,
    output logic              x8_mode,
    output logic              prog_req,
    output prg_op_t           prog_op,
    output logic [ADDR_W:0]   prog_addr,
    output logic [DATA_W-1:0] prog_data
);

    localparam int AW8   = ADDR_W + 1;
    localparam int HALF  = DATA_W / 2;
    localparam int CNT_W = $clog2(3 + AW8 + DATA_W);

    fr_state_t         st;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        opc;
    logic [AW8-1:0]    addr;
    logic [DATA_W-1:0] data;
    logic              wen_q;

    logic [CNT_W-1:0]  last_addr_cnt;
    logic [CNT_W-1:0]  last_data_cnt;
    logic [AW8-1:0]    addr_nxt;
    logic [1:0]        sub_nxt;
    logic [1:0]        sub_cur;
    logic              at_addr_end;
    logic              at_data_end;
    logic              kind_ok;
    prg_op_t           kind;

    // Returns the two most significant address bits for the current organisation.
    function automatic logic [1:0] sub_of(input logic [AW8-1:0] a, input logic m8);
        return m8 ? a[AW8-1:AW8-2] : a[ADDR_W-1:ADDR_W-2];
    endfunction

    // Bit positions that end the address and the data fields.
    always_comb begin
        last_addr_cnt = x8_mode ? CNT_W'(1 + AW8) : CNT_W'(1 + ADDR_W);
        last_data_cnt = last_addr_cnt + (x8_mode ? CNT_W'(HALF) : CNT_W'(DATA_W));
        addr_nxt      = {addr[AW8-2:0], di};
        sub_nxt       = sub_of(addr_nxt, x8_mode);
        sub_cur       = sub_of(addr, x8_mode);
        at_addr_end   = (cnt == last_addr_cnt);
        at_data_end   = (cnt == last_data_cnt);
    end

    // Maps the received opcode and sub-command to a programming request kind.
    always_comb begin
        kind_ok = 1'b1;
        kind    = PRG_WRITE;
        case (opc)
            OPC_WRITE: kind = PRG_WRITE;
            OPC_ERASE: kind = PRG_ERASE;
            OPC_EXT: begin
                case (sub_cur)
                    SUB_CLEAR: kind = PRG_ERAL;
                    SUB_FILL:  kind = PRG_WRAL;
                    default:   kind_ok = 1'b0;
                endcase
            end
            default: kind_ok = 1'b0;
        endcase
    end

    // Frame state, bit counter, field shift registers and programming lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= FR_WAIT;
            cnt     <= '0;
            opc     <= '0;
            addr    <= '0;
            data    <= '0;
            x8_mode <= 1'b0;
            wen_q   <= 1'b0;
        end else if (!cs) begin
            st  <= FR_WAIT;
            cnt <= '0;
        end else if (sclk_rise) begin
            case (st)
                FR_WAIT: begin
                    if (di) begin
                        st      <= FR_SHIFT;
                        cnt     <= '0;
                        opc     <= '0;
                        addr    <= '0;
                        data    <= '0;
                        x8_mode <= ~org;
                    end
                end
                FR_SHIFT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt < CNT_W'(2))
                        opc <= {opc[0], di};
                    else if (cnt <= last_addr_cnt)
                        addr <= addr_nxt;
                    else
                        data <= {data[DATA_W-2:0], di};
                    if (at_addr_end) begin
                        if (opc == OPC_READ)
                            st <= FR_READ;
                        else if (opc == OPC_WRITE || (opc == OPC_EXT && sub_nxt == SUB_FILL))
                            st <= FR_SHIFT;
                        else begin
                            st <= FR_DONE;
                            if (opc == OPC_EXT && sub_nxt == SUB_UNLOCK) wen_q <= 1'b1;
                            if (opc == OPC_EXT && sub_nxt == SUB_LOCK)   wen_q <= 1'b0;
                        end
                    end else if (cnt > last_addr_cnt && at_data_end) begin
                        st <= FR_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // Read launch, request strobe and request fields.
    always_comb begin
        rd_start  = cs && sclk_rise && (st == FR_SHIFT) && at_addr_end && (opc == OPC_READ);
        rd_addr   = x8_mode ? addr_nxt : {1'b0, addr_nxt[ADDR_W-1:0]};
        prog_req  = cs_fall && (st == FR_DONE) && wen_q && kind_ok;
        prog_op   = kind;
        prog_addr = x8_mode ? addr : {1'b0, addr[ADDR_W-1:0]};
        prog_data = data;
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req); // R10
    AST_UNLOCK_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wen_q) |-> ($past(st) == FR_SHIFT)); // R4
    AST_DONE_IGNORES_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_DONE && cs) |=> (st == FR_DONE)); // R8
    AST_DESELECT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (st == FR_WAIT)); // R9

endmodule

// File: rtl/mw_read_out.sv
// Read shifter: sends the leading zero, then the bits of each location MSB
// first, and advances the address with wrap while select stays high.
// Assumes: word_in is the combinational content of location cur_addr.
module mw_read_out #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sclk_rise,
    input  logic              rd_start,
    input  logic [ADDR_W:0]   start_addr,
    input  logic              x8_mode,
    input  logic [DATA_W-1:0] word_in,
    output logic [ADDR_W:0]   cur_addr,
    output logic              bit_q,
    output logic              oe_q
);

    localparam int AW8   = ADDR_W + 1;
    localparam int IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [AW8-1:0]   nxt_addr;

    // Last bit index of a location and the wrapped next address.
    always_comb begin
        last_idx = x8_mode ? IDX_W'(DATA_W / 2 - 1) : IDX_W'(DATA_W - 1);
        nxt_addr = x8_mode ? AW8'(cur_addr + 1'b1)
                           : {1'b0, ADDR_W'(cur_addr[ADDR_W-1:0] + 1'b1)};
    end

    // Output bit register, bit index and streaming address.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs) begin
            oe_q     <= 1'b0;
            bit_q    <= 1'b0;
            idx      <= '0;
            cur_addr <= '0;
        end else if (rd_start) begin
            oe_q     <= 1'b1;
            bit_q    <= 1'b0;
            idx      <= '0;
            cur_addr <= start_addr;
        end else if (oe_q && sclk_rise) begin
            bit_q <= word_in[last_idx - idx];
            if (idx == last_idx) begin
                idx      <= '0;
                cur_addr <= nxt_addr;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !bit_q); // R6
    AST_DO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !sclk_rise) |=> $stable(bit_q)); // R2

endmodule

// File: rtl/mw_word_store.sv
// Word array: combinational read in either organisation, and commit of
// programming requests in the cycle they are issued.
// Assumes: prog_* fields are valid only while prog_req is high.
module mw_word_store
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x8_mode,
    input  logic [ADDR_W:0]   raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              prog_req,
    input  prg_op_t           prog_op,
    input  logic [ADDR_W:0]   prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              prog_x8
);

    localparam int DEPTH = 2 ** ADDR_W;
    localparam int HALF  = DATA_W / 2;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] rword_idx;
    logic [DATA_W-1:0] rword;
    logic [ADDR_W-1:0] tgt;
    logic [DATA_W-1:0] fill;
    logic [DATA_W-1:0] one_word;
    logic [DATA_W-1:0] all_word;

    // Read path: select the word, then the byte half in byte mode.
    always_comb begin
        rword_idx = x8_mode ? raddr[ADDR_W:1] : raddr[ADDR_W-1:0];
        rword     = mem[rword_idx];
        if (!x8_mode)
            rdata = rword;
        else if (raddr[0])
            rdata = {{HALF{1'b0}}, rword[DATA_W-1:HALF]};
        else
            rdata = {{HALF{1'b0}}, rword[HALF-1:0]};
    end

    // New content for a single-location update and for a whole-array update.
    always_comb begin
        tgt  = prog_x8 ? prog_addr[ADDR_W:1] : prog_addr[ADDR_W-1:0];
        fill = (prog_op == PRG_ERASE) ? '1 : prog_data;
        if (!prog_x8)
            one_word = fill;
        else if (prog_addr[0])
            one_word = {fill[HALF-1:0], mem[tgt][HALF-1:0]};
        else
            one_word = {mem[tgt][DATA_W-1:HALF], fill[HALF-1:0]};
        if (prog_op == PRG_ERAL)
            all_word = '1;
        else if (prog_x8)
            all_word = {prog_data[HALF-1:0], prog_data[HALF-1:0]};
        else
            all_word = prog_data;
    end

    // Array update: erased on reset, then committed per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '1;
        end else if (prog_req) begin
            if (prog_op == PRG_WRITE || prog_op == PRG_ERASE)
                mem[tgt] <= one_word;
            else
                for (int w = 0; w < DEPTH; w++) mem[w] <= all_word;
        end
    end

    AST_ERAL_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && prog_op == PRG_ERAL) |=> (mem[0] == '1 && mem[DEPTH-1] == '1)); // R11

endmodule

// File: rtl/mw_serial_eeprom.sv
// Top level: edge detection of the serial pins in the system clock domain,
// and wiring of frame receiver, read shifter and word array.
// Assumes: cs, sclk and di are already synchronous to clk, and each sclk
// level lasts at least one clk cycle.
module mw_serial_eeprom
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sclk,
    input  logic              di,
    input  logic              org,
    output logic              do_o,
    output logic              do_oe,
    output logic              prog_req,
    output logic [1:0]        prog_op,
    output logic [ADDR_W:0]   prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              prog_x8
);

    logic              sclk_q;
    logic              cs_q;
    logic              sclk_rise;
    logic              cs_fall;
    logic              rd_start;
    logic [ADDR_W:0]   rd_addr;
    logic              x8_mode;
    prg_op_t           op_int;
    logic [ADDR_W:0]   cur_addr;
    logic [DATA_W-1:0] word;
    logic              bit_q;
    logic              oe_q;

    // Previous levels of the serial clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs;
        end
    end

    // Edge strobes and pad outputs; DO is released as soon as cs is low.
    always_comb begin
        sclk_rise = cs && sclk && !sclk_q;
        cs_fall   = cs_q && !cs;
        do_oe     = oe_q && cs;
        do_o      = do_oe && bit_q;
        prog_op   = op_int;
        prog_x8   = x8_mode;
    end

    mw_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .cs_fall   (cs_fall),
        .sclk_rise (sclk_rise),
        .di        (di),
        .org       (org),
        .rd_start  (rd_start),
        .rd_addr   (rd_addr),
        .x8_mode   (x8_mode),
        .prog_req  (prog_req),
        .prog_op   (op_int),
        .prog_addr (prog_addr),
        .prog_data (prog_data)
    );

    mw_read_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .sclk_rise  (sclk_rise),
        .rd_start   (rd_start),
        .start_addr (rd_addr),
        .x8_mode    (x8_mode),
        .word_in    (word),
        .cur_addr   (cur_addr),
        .bit_q      (bit_q),
        .oe_q       (oe_q)
    );

    mw_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .x8_mode   (x8_mode),
        .raddr     (cur_addr),
        .rdata     (word),
        .prog_req  (prog_req),
        .prog_op   (op_int),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .prog_x8   (x8_mode)
    );

endmodule

// File: tb/tb_mw_serial_eeprom.sv
`timescale 1ns/1ps
module tb_mw_serial_eeprom;

    localparam int AW = 6;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1;
    logic do_o, do_oe, prog_req, prog_x8;
    logic [1:0] prog_op;
    logic [AW:0] prog_addr;
    logic [DW-1:0] prog_data;

    mw_serial_eeprom #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di), .org(org),
        .do_o(do_o), .do_oe(do_oe), .prog_req(prog_req), .prog_op(prog_op),
        .prog_addr(prog_addr), .prog_data(prog_data), .prog_x8(prog_x8)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    bit mon_on = 0;
    string tag = "R9";

    // Reference model state
    logic [7:0] mbytes [2**(AW+1)];
    bit m_wen, m_x8;
    int m_state, m_cnt, m_op, m_addr, m_data, m_raddr;
    int q[$];
    bit exp_oe, exp_do, exp_req;
    int exp_op, exp_addr, exp_data;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int mword(input int a);
        if (m_x8) return mbytes[a];
        return {mbytes[2*a+1], mbytes[2*a]};
    endfunction

    task automatic model_rise(input bit b);
        int al, dl, sub, w;
        al = m_x8 ? AW + 1 : AW;
        dl = m_x8 ? DW / 2 : DW;
        case (m_state)
            0: if (b) begin
                m_state = 1; m_cnt = 0; m_op = 0; m_addr = 0; m_data = 0; m_x8 = !org;
            end
            1: begin
                if (m_cnt < 2) m_op = m_op * 2 + b;
                else if (m_cnt < 2 + al) m_addr = m_addr * 2 + b;
                else m_data = m_data * 2 + b;
                m_cnt++;
                if (m_cnt == 2 + al) begin
                    sub = m_addr >> (al - 2);
                    if (m_op == 2) begin
                        m_state = 2; m_raddr = m_addr; exp_oe = 1; exp_do = 0;
                    end else if (!(m_op == 1 || (m_op == 0 && sub == 1))) begin
                        if (m_op == 0 && sub == 3) m_wen = 1;
                        if (m_op == 0 && sub == 0) m_wen = 0;
                        m_state = 3;
                    end
                end else if (m_cnt == 2 + al + dl) begin
                    m_state = 3;
                end
            end
            2: begin
                if (q.size() == 0) begin
                    w = mword(m_raddr);
                    for (int i = dl - 1; i >= 0; i--) q.push_back((w >> i) & 1);
                    m_raddr = (m_raddr + 1) % (1 << al);
                end
                exp_do = q.pop_front();
            end
            default: ;
        endcase
    endtask

    task automatic model_cs_low();
        int al, kind, sub;
        al = m_x8 ? AW + 1 : AW;
        kind = -1;
        if (m_state == 3) begin
            sub = m_addr >> (al - 2);
            if (m_op == 1) kind = 0;
            else if (m_op == 3) kind = 1;
            else if (m_op == 0 && sub == 2) kind = 2;
            else if (m_op == 0 && sub == 1) kind = 3;
        end
        if (kind >= 0 && m_wen) begin
            exp_req = 1; exp_op = kind; exp_addr = m_addr; exp_data = m_data;
            case (kind)
                0, 1: begin
                    if (m_x8) mbytes[m_addr] = (kind == 1) ? 8'hFF : m_data[7:0];
                    else begin
                        mbytes[2*m_addr]   = (kind == 1) ? 8'hFF : m_data[7:0];
                        mbytes[2*m_addr+1] = (kind == 1) ? 8'hFF : m_data[15:8];
                    end
                end
                2: for (int i = 0; i < 2**(AW+1); i++) mbytes[i] = 8'hFF;
                default: for (int i = 0; i < 2**(AW+1); i++)
                    mbytes[i] = m_x8 ? m_data[7:0] : ((i % 2) ? m_data[15:8] : m_data[7:0]);
            endcase
        end
        m_state = 0;
        exp_oe = 0;
        q.delete();
    endtask

    // DO and its enable compared on every clock, away from the edges
    always @(posedge clk) if (mon_on) begin
        #2;
        chk(tag, do_oe, exp_oe);
        if (exp_oe) chk(tag, do_o, exp_do);
    end

    // Programming request compared on every clock
    always @(negedge clk) if (mon_on) begin
        #2;
        chk("R10", prog_req, exp_req);
        if (exp_req && prog_req) begin
            chk("R10", prog_op, exp_op);
            if (exp_op <= 1) chk("R10", prog_addr, exp_addr);
            if (exp_op == 0 || exp_op == 3) chk("R11", prog_data, exp_data);
            chk("R5", prog_x8, m_x8);
        end
    end

    task automatic pulse(input bit b);
        @(negedge clk); sclk = 0; di = b;
        @(negedge clk);
        @(negedge clk); sclk = 1; model_rise(b);
        @(negedge clk);
    endtask

    task automatic send(input longint v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic cs_high();
        @(negedge clk); cs = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_low();
        @(negedge clk); cs = 0; sclk = 0; model_cs_low();
        @(negedge clk); exp_req = 0;
        repeat (2) @(negedge clk);
    endtask

    function automatic int flen(input bit wd);
        return 3 + (org ? AW : AW + 1) + (wd ? (org ? DW : DW / 2) : 0);
    endfunction

    function automatic longint fbits(input int op, input int a, input int d, input bit wd);
        longint v;
        v = 4 + op;
        v = (v << (org ? AW : AW + 1)) | a;
        if (wd) v = (v << (org ? DW : DW / 2)) | d;
        return v;
    endfunction

    task automatic txn(input int op, input int a, input int d, input bit wd,
                       input int extra, input bit xv);
        cs_high();
        send(fbits(op, a, d, wd), flen(wd));
        for (int i = 0; i < extra; i++) pulse(xv);
        cs_low();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2**(AW+1); i++) mbytes[i] = 8'hFF;
        m_wen = 0; m_state = 0; m_x8 = 0;
        exp_oe = 0; exp_do = 0; exp_req = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9", do_oe, 0);
        chk("R10", prog_req, 0);
        mon_on = 1;

        // R1: clocks with di low before the start bit are ignored
        tag = "R1";
        cs_high();
        send(0, 5);
        send(fbits(2, 5, 0, 0), flen(0));
        send(0, 17);
        cs_low();

        // R10: writing while locked after reset produces no request
        tag = "R10";
        txn(1, 5, 'hA5C3, 1, 0, 0);
        txn(2, 5, 0, 0, 17, 0);

        // R4: unlock, then R3 writes and reads in word mode
        tag = "R4";
        txn(0, 3 << (AW - 2), 0, 0, 0, 0);
        tag = "R3";
        txn(1, 5, 'hA5C3, 1, 0, 0);
        txn(1, 63, 'h1234, 1, 0, 0);
        txn(1, 0, 'hBEEF, 1, 0, 0);
        tag = "R6";
        txn(2, 5, 0, 0, 17, 0);

        // R7: stream across the top address and wrap to 0
        tag = "R7";
        txn(2, 63, 0, 0, 51, 0);

        // R8: truncated write is dropped; trailing clocks after erase ignored
        tag = "R8";
        cs_high();
        send(fbits(1, 7, 'h1111, 1) >> 5, 20);
        cs_low();
        txn(2, 7, 0, 0, 17, 0);
        txn(3, 5, 0, 0, 6, 1);
        txn(2, 5, 0, 0, 17, 0);

        // R9: read cut short by deselect, then a fresh frame works
        tag = "R9";
        txn(2, 0, 0, 0, 6, 0);
        txn(2, 0, 0, 0, 17, 0);

        // R5: byte mode with one more address bit
        tag = "R5";
        @(negedge clk); org = 0;
        txn(1, 11, 'h77, 1, 0, 0);
        txn(1, 10, 'h12, 1, 0, 0);
        txn(2, 10, 0, 0, 18, 0);
        tag = "R7";
        txn(2, 127, 0, 0, 17, 0);

        // R11: write-all in byte mode, check in both modes, then erase-all
        tag = "R11";
        txn(0, 1 << (AW - 1), 'h3C, 1, 0, 0);
        txn(2, 3, 0, 0, 26, 0);
        @(negedge clk); org = 1;
        txn(2, 9, 0, 0, 17, 0);
        tag = "R2";
        txn(0, 2 << (AW - 2), 0, 0, 0, 0);
        txn(2, 9, 0, 0, 17, 0);

        // R4: lock again; a later write is not requested or stored
        tag = "R4";
        txn(0, 0, 0, 0, 0, 0);
        txn(1, 2, 'h5555, 1, 0, 0);
        txn(2, 2, 0, 0, 17, 0);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule